// File: doc/BRIEF.md
# USB Endpoint Command and Status Controller

This block is the processor-side command engine of a full-speed USB device controller with sixteen endpoint slots. Slot 0 is the control OUT endpoint, slot 1 the control IN endpoint, and slots 2 to 15 carry general endpoints 1 to 14. The processor writes 8-bit command codes. The block turns each code into one of five actions: stall, unstall, validate an IN buffer, clear an OUT buffer, or read a status word. For every slot it keeps a stall bit, two buffer-full flags, a data-toggle bit, and two ping-pong pointers. One pointer selects the FIFO the processor works on. The other selects the FIFO the bus side serves next.

The serial engine reports bus activity through single-cycle strobes: a SETUP token, a token with its direction and endpoint, and an acknowledged packet transfer. The block answers each token with ACK, NAK or STALL. It tracks buffer ownership so that a full OUT buffer refuses new data until the processor releases it. It also returns an endpoint to a clean DATA0 state whenever the endpoint leaves the stalled condition. Packet serialisation, CRC, the FIFO storage and interrupt generation are outside this block.

Top module: `usb_ep_cmd_ctrl`

## Requirements
- R1: A code 0x40+n sets the stall bit of slot n. One cycle after a token to a stalled slot, `resp_code` is 2'b11 (STALL) with `resp_valid` high.
- R2: A code 0x80+n clears the stall bit of slot n. It also clears both full flags, the data toggle and both ping-pong pointers of that slot.
- R3: A `setup_stb` pulse unstalls and re-initialises slots 0 and 1 as in R2, whatever their state. If a command acts on the same slot in the same cycle, the strobe is applied first and the command second, so a stall command in that cycle leaves the slot stalled.
- R4: A code 0x60+n with n from 1 to 15 sets the full flag of the processor-side FIFO of slot n. An IN token to an IN slot answers ACK (2'b01) when the bus-side FIFO is full and NAK (2'b10) when it is empty.
- R5: A code 0x70, or 0x70+n with n from 2 to 15, clears the full flag of the processor-side FIFO of that slot.
- R6: An acknowledged transfer on an OUT slot sets the full flag of its bus-side FIFO. An OUT token answers NAK while that FIFO is full and ACK while it is empty.
- R7: An acknowledged transfer flips the data toggle. On an IN slot it also clears the full flag of the FIFO that was sent. A transfer to a stalled slot, or to a bus-side FIFO in the wrong fill state, changes nothing. When a transfer and a command reach the same slot in one cycle, the transfer is applied first.
- R8: On a double-buffered slot (default: slots 2 to 15), each validate or clear command swaps the processor-side pointer and each accepted transfer swaps the bus-side pointer. On single-buffered slots (0 and 1) both pointers stay at FIFO 0.
- R9: A code 0xD0+n raises `stat_valid` one cycle later, with `stat_word` holding the state of slot n. The layout is: bit 0 the processor-side pointer, bit 1 the FIFO 0 full flag, bit 2 the FIFO 1 full flag, bit 3 the toggle, bit 4 the stall bit, and zero in all other bits. The read changes no state.
- R10: Any other code, including 0x60 and 0x71, changes no state and raises `cmd_err` for exactly one cycle, one cycle after the command.
- R11: A token whose direction does not match the slot's direction answers STALL. By default the even slots are OUT and the odd slots are IN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code: action in the high nibble, slot in the low nibble |
| cmd_err | output | 1 | One-cycle pulse for an invalid code |
| stat_valid | output | 1 | Status word valid |
| stat_word | output | 16 | Status of the slot that was read |
| setup_stb | input | 1 | SETUP token seen on the control endpoint |
| tok_valid | input | 1 | Token strobe |
| tok_in | input | 1 | 1 = IN token, 0 = OUT token |
| tok_ep | input | 4 | Slot addressed by the token |
| resp_valid | output | 1 | Handshake answer valid |
| resp_code | output | 2 | 01 ACK, 10 NAK, 11 STALL |
| xfer_done | input | 1 | Packet transfer acknowledged |
| xfer_ep | input | 4 | Slot of the acknowledged transfer |

## Verification
Every result the block returns is registered once. The handshake for a token, the status word for a read, and the error pulse for a bad code therefore all appear on the clock edge that samples the request. The bench drives each stimulus just after a falling edge and reads the outputs at the next falling edge, which lies between the producing edge and the one after it. State changes made by a command or a transfer show only through a later status read or token, so each such check is made one full step after the action that caused it. Same-cycle collisions are driven as a single step, so the ordering of bus event before command can be seen in the next status read.

// File: rtl/ep_cmd_pkg.sv
package ep_cmd_pkg;
  localparam int EP_SLOTS = 16;
  localparam int SLOT_W   = $clog2(EP_SLOTS);
  localparam int FIFO_N   = 2;
  localparam int STAT_W   = 16;

  // fixed slot roles
  localparam logic [SLOT_W-1:0] SLOT_CTRL_OUT = 4'd0;
  localparam logic [SLOT_W-1:0] SLOT_CTRL_IN  = 4'd1;

  // command high nibbles
  localparam logic [3:0] OPC_STALL   = 4'h4;
  localparam logic [3:0] OPC_VALID   = 4'h6;
  localparam logic [3:0] OPC_CLEAR   = 4'h7;
  localparam logic [3:0] OPC_UNSTALL = 4'h8;
  localparam logic [3:0] OPC_STATUS  = 4'hD;

  // status word field positions
  localparam int ST_PTR   = 0;
  localparam int ST_FULL0 = 1;
  localparam int ST_FULL1 = 2;
  localparam int ST_TOG   = 3;
  localparam int ST_STALL = 4;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_STALL,
    OP_UNSTALL,
    OP_VALID,
    OP_CLEAR,
    OP_STAT
  } ep_op_e;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'b00,
    RSP_ACK   = 2'b01,
    RSP_NAK   = 2'b10,
    RSP_STALL = 2'b11
  } ep_rsp_e;
endpackage

// File: rtl/ep_cmd_decode.sv
module ep_cmd_decode
  import ep_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  output ep_op_e            op_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              err_q
);
  logic [3:0] opc;
  logic       bad;
  logic       err_d;

  assign opc    = cmd_code[7:4];
  assign slot_o = cmd_code[SLOT_W-1:0];

  always_comb begin
    op_o = OP_NONE;
    bad  = 1'b0;
    if (cmd_valid) begin
      case (opc)
        OPC_STALL:   op_o = OP_STALL;
        OPC_UNSTALL: op_o = OP_UNSTALL;
        OPC_STATUS:  op_o = OP_STAT;
        OPC_VALID: begin
          if (slot_o == SLOT_CTRL_OUT) bad = 1'b1;
          else                         op_o = OP_VALID;
        end
        OPC_CLEAR: begin
          if (slot_o == SLOT_CTRL_IN) bad = 1'b1;
          else                        op_o = OP_CLEAR;
        end
        default: bad = 1'b1;
      endcase
    end
  end

  assign err_d = bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  // R10: an error pulse only follows a command that produced no action
  a_r10_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($past(cmd_valid) && ($past(op_o) == OP_NONE)));
endmodule

// File: rtl/ep_slot.sv
module ep_slot
  import ep_cmd_pkg::*;
#(
  parameter bit IS_IN = 1'b0,
  parameter bit DBL   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_hit,
  input  logic              xfer_hit,
  input  ep_op_e            op,
  output logic              stall_q,
  output logic [FIFO_N-1:0] full_q,
  output logic              tog_q,
  output logic              cpu_ptr_q,
  output logic              usb_ptr_q
);
  logic              stall_d;
  logic [FIFO_N-1:0] full_d;
  logic              tog_d;
  logic              cpu_d;
  logic              usb_d;
  logic              upd_en;

  always_comb begin
    stall_d = stall_q;
    full_d  = full_q;
    tog_d   = tog_q;
    cpu_d   = cpu_ptr_q;
    usb_d   = usb_ptr_q;
    // bus side first
    if (setup_hit) begin
      stall_d = 1'b0;
      full_d  = '0;
      tog_d   = 1'b0;
      cpu_d   = 1'b0;
      usb_d   = 1'b0;
    end else if (xfer_hit && !stall_q) begin
      // IN drains a full FIFO, OUT fills an empty one
      if (full_q[usb_ptr_q] == IS_IN) begin
        full_d[usb_ptr_q] = !IS_IN;
        tog_d             = !tog_q;
        usb_d             = usb_ptr_q ^ DBL;
      end
    end
    // processor command second
    case (op)
      OP_STALL:   stall_d = 1'b1;
      OP_UNSTALL: begin
        stall_d = 1'b0;
        full_d  = '0;
        tog_d   = 1'b0;
        cpu_d   = 1'b0;
        usb_d   = 1'b0;
      end
      OP_VALID: begin
        full_d[cpu_d] = 1'b1;
        cpu_d         = cpu_d ^ DBL;
      end
      OP_CLEAR: begin
        full_d[cpu_d] = 1'b0;
        cpu_d         = cpu_d ^ DBL;
      end
      default: ;
    endcase
  end

  assign upd_en = setup_hit | xfer_hit |
                  (op == OP_STALL) | (op == OP_UNSTALL) |
                  (op == OP_VALID) | (op == OP_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q   <= 1'b0;
      full_q    <= '0;
      tog_q     <= 1'b0;
      cpu_ptr_q <= 1'b0;
      usb_ptr_q <= 1'b0;
    end else if (upd_en) begin
      stall_q   <= stall_d;
      full_q    <= full_d;
      tog_q     <= tog_d;
      cpu_ptr_q <= cpu_d;
      usb_ptr_q <= usb_d;
    end
  end

  a_r1_stall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STALL) |=> stall_q);

  a_r2_unstall_reinit: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_UNSTALL) |=> (!stall_q && (full_q == '0) && !tog_q &&
                            !cpu_ptr_q && !usb_ptr_q));

  a_r3_setup_reinit: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_hit && (op == OP_NONE)) |=> (!stall_q && (full_q == '0) && !tog_q));

  a_r7_stalled_xfer_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_hit && stall_q && !setup_hit && (op == OP_NONE)) |=>
      ($stable(full_q) && $stable(tog_q) && $stable(usb_ptr_q)));

  a_r8_cpu_ptr_swap: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_VALID) || (op == OP_CLEAR)) && !setup_hit |=>
      (cpu_ptr_q == ($past(cpu_ptr_q) ^ DBL)));
endmodule

// File: rtl/ep_token_resp.sv
module ep_token_resp
  import ep_cmd_pkg::*;
#(
  parameter logic [EP_SLOTS-1:0] IN_MASK = 16'hAAAA
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tok_valid,
  input  logic                       tok_in,
  input  logic [SLOT_W-1:0]          tok_slot,
  input  logic [EP_SLOTS-1:0]        stall_vec,
  input  logic [EP_SLOTS*FIFO_N-1:0] full_flat,
  input  logic [EP_SLOTS-1:0]        usb_ptr_vec,
  output logic                       resp_valid_q,
  output logic [1:0]                 resp_code_q
);
  logic    sel_full;
  ep_rsp_e rsp_d;

  assign sel_full = full_flat[FIFO_N*tok_slot + int'(usb_ptr_vec[tok_slot])];

  always_comb begin
    if (stall_vec[tok_slot])             rsp_d = RSP_STALL;
    else if (tok_in != IN_MASK[tok_slot]) rsp_d = RSP_STALL;
    else if (tok_in)                     rsp_d = sel_full ? RSP_ACK : RSP_NAK;
    else                                 rsp_d = sel_full ? RSP_NAK : RSP_ACK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_valid_q <= 1'b0;
    else        resp_valid_q <= tok_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         resp_code_q <= RSP_NONE;
    else if (tok_valid) resp_code_q <= rsp_d;
  end

  a_r1_stall_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && stall_vec[tok_slot]) |=> (resp_valid_q && (resp_code_q == RSP_STALL)));

  a_r11_dir_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && (tok_in != IN_MASK[tok_slot])) |=> (resp_code_q == RSP_STALL));
endmodule

// File: rtl/ep_status_mux.sv
module ep_status_mux
  import ep_cmd_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       stat_req,
  input  logic [SLOT_W-1:0]          stat_slot,
  input  logic [EP_SLOTS-1:0]        stall_vec,
  input  logic [EP_SLOTS*FIFO_N-1:0] full_flat,
  input  logic [EP_SLOTS-1:0]        tog_vec,
  input  logic [EP_SLOTS-1:0]        cpu_ptr_vec,
  output logic                       stat_valid_q,
  output logic [STAT_W-1:0]          stat_word_q
);
  logic [STAT_W-1:0] word_d;

  always_comb begin
    word_d           = '0;
    word_d[ST_PTR]   = cpu_ptr_vec[stat_slot];
    word_d[ST_FULL0] = full_flat[FIFO_N*stat_slot];
    word_d[ST_FULL1] = full_flat[FIFO_N*stat_slot + 1];
    word_d[ST_TOG]   = tog_vec[stat_slot];
    word_d[ST_STALL] = stall_vec[stat_slot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_valid_q <= 1'b0;
    else        stat_valid_q <= stat_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stat_word_q <= '0;
    else if (stat_req) stat_word_q <= word_d;
  end

  a_r9_stall_field: assert property (@(posedge clk) disable iff (!rst_n)
    stat_req |=> (stat_valid_q && (stat_word_q[ST_STALL] == $past(stall_vec[stat_slot]))));
endmodule

// File: rtl/usb_ep_cmd_ctrl.sv
module usb_ep_cmd_ctrl
  import ep_cmd_pkg::*;
#(
  parameter logic [EP_SLOTS-1:0] DBL_MASK = 16'hFFFC,
  parameter logic [EP_SLOTS-1:0] IN_MASK  = 16'hAAAA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_code,
  output logic        cmd_err,
  output logic        stat_valid,
  output logic [15:0] stat_word,
  input  logic        setup_stb,
  input  logic        tok_valid,
  input  logic        tok_in,
  input  logic [3:0]  tok_ep,
  output logic        resp_valid,
  output logic [1:0]  resp_code,
  input  logic        xfer_done,
  input  logic [3:0]  xfer_ep
);
  localparam int CTRL_SLOTS = 2;

  logic [1:0]                 rst_pipe;
  logic                       rst_sn;
  ep_op_e                     dec_op;
  logic [SLOT_W-1:0]          dec_slot;
  logic [EP_SLOTS-1:0]        stall_vec;
  logic [EP_SLOTS-1:0]        tog_vec;
  logic [EP_SLOTS-1:0]        cpu_ptr_vec;
  logic [EP_SLOTS-1:0]        usb_ptr_vec;
  logic [EP_SLOTS*FIFO_N-1:0] full_flat;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  ep_cmd_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_sn),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .op_o      (dec_op),
    .slot_o    (dec_slot),
    .err_q     (cmd_err)
  );

  for (genvar i = 0; i < EP_SLOTS; i++) begin : g_slot
    ep_op_e            slot_op;
    logic              slot_setup;
    logic              slot_xfer;
    logic [FIFO_N-1:0] slot_full;

    assign slot_op    = (dec_slot == SLOT_W'(i)) ? dec_op : OP_NONE;
    assign slot_setup = setup_stb && (i < CTRL_SLOTS);
    assign slot_xfer  = xfer_done && (xfer_ep == SLOT_W'(i));
    assign full_flat[FIFO_N*i +: FIFO_N] = slot_full;

    ep_slot #(
      .IS_IN (IN_MASK[i]),
      .DBL   (DBL_MASK[i])
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_sn),
      .setup_hit (slot_setup),
      .xfer_hit  (slot_xfer),
      .op        (slot_op),
      .stall_q   (stall_vec[i]),
      .full_q    (slot_full),
      .tog_q     (tog_vec[i]),
      .cpu_ptr_q (cpu_ptr_vec[i]),
      .usb_ptr_q (usb_ptr_vec[i])
    );
  end

  ep_token_resp #(.IN_MASK(IN_MASK)) u_resp (
    .clk          (clk),
    .rst_n        (rst_sn),
    .tok_valid    (tok_valid),
    .tok_in       (tok_in),
    .tok_slot     (tok_ep),
    .stall_vec    (stall_vec),
    .full_flat    (full_flat),
    .usb_ptr_vec  (usb_ptr_vec),
    .resp_valid_q (resp_valid),
    .resp_code_q  (resp_code)
  );

  ep_status_mux u_stat (
    .clk          (clk),
    .rst_n        (rst_sn),
    .stat_req     (dec_op == OP_STAT),
    .stat_slot    (dec_slot),
    .stall_vec    (stall_vec),
    .full_flat    (full_flat),
    .tog_vec      (tog_vec),
    .cpu_ptr_vec  (cpu_ptr_vec),
    .stat_valid_q (stat_valid),
    .stat_word_q  (stat_word)
  );

  // R10: a rejected code never produces a status word
  a_r10_err_no_status: assert property (@(posedge clk) disable iff (!rst_sn)
    !(cmd_err && stat_valid));

  // R8: control slots are single-buffered, both pointers stay at FIFO 0
  a_r8_ctrl_single: assert property (@(posedge clk) disable iff (!rst_sn)
    (!cpu_ptr_vec[0] && !usb_ptr_vec[0] && !cpu_ptr_vec[1] && !usb_ptr_vec[1]));
endmodule

// File: tb/usb_ep_cmd_ctrl_tb_top.sv
module usb_ep_cmd_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [7:0]  cmd_code;
  logic        cmd_err;
  logic        stat_valid;
  logic [15:0] stat_word;
  logic        setup_stb;
  logic        tok_valid;
  logic        tok_in;
  logic [3:0]  tok_ep;
  logic        resp_valid;
  logic [1:0]  resp_code;
  logic        xfer_done;
  logic [3:0]  xfer_ep;

  int n_tests = 0;
  int n_fail  = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  usb_ep_cmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_err(cmd_err),
    .stat_valid(stat_valid), .stat_word(stat_word),
    .setup_stb(setup_stb),
    .tok_valid(tok_valid), .tok_in(tok_in), .tok_ep(tok_ep),
    .resp_valid(resp_valid), .resp_code(resp_code),
    .xfer_done(xfer_done), .xfer_ep(xfer_ep)
  );

  localparam logic [1:0] K_CMD = 2'd0, K_IN = 2'd1, K_OUT = 2'd2, K_XFR = 2'd3;
  localparam logic [15:0] NO_CHK = 16'hFFFF, ERR_EXP = 16'hEEEE;
  localparam int NV = 31;
  // {requirement, kind, argument, expected}
  localparam logic [29:0] VEC [NV] = '{
    {4'd9,  K_CMD, 8'hD3, 16'h0000},  // R9 reset state of slot 3
    {4'd4,  K_IN,  8'h03, 16'h0002},  // R4 empty IN -> NAK
    {4'd4,  K_CMD, 8'h63, NO_CHK},    // R4 validate
    {4'd8,  K_CMD, 8'hD3, 16'h0003},  // R8 cpu pointer swapped
    {4'd4,  K_IN,  8'h03, 16'h0001},  // R4 full IN -> ACK
    {4'd7,  K_XFR, 8'h03, NO_CHK},    // R7 IN sent
    {4'd7,  K_CMD, 8'hD3, 16'h0009},  // R7 toggle flipped, FIFO drained
    {4'd8,  K_IN,  8'h03, 16'h0002},  // R8 bus side now on FIFO 1
    {4'd8,  K_CMD, 8'h63, NO_CHK},
    {4'd8,  K_CMD, 8'hD3, 16'h000C},
    {4'd8,  K_IN,  8'h03, 16'h0001},
    {4'd1,  K_CMD, 8'h43, NO_CHK},    // R1 stall
    {4'd1,  K_IN,  8'h03, 16'h0003},
    {4'd9,  K_CMD, 8'hD3, 16'h001C},  // R9 all fields
    {4'd2,  K_CMD, 8'h83, NO_CHK},    // R2 unstall
    {4'd2,  K_CMD, 8'hD3, 16'h0000},
    {4'd6,  K_OUT, 8'h00, 16'h0001},  // R6 empty OUT -> ACK
    {4'd6,  K_XFR, 8'h00, NO_CHK},
    {4'd6,  K_OUT, 8'h00, 16'h0002},  // R6 full OUT -> NAK
    {4'd9,  K_CMD, 8'hD0, 16'h000A},
    {4'd5,  K_CMD, 8'h70, NO_CHK},    // R5 clear
    {4'd5,  K_CMD, 8'hD0, 16'h0008},
    {4'd5,  K_OUT, 8'h00, 16'h0001},
    {4'd10, K_CMD, 8'h60, ERR_EXP},   // R10 bad codes
    {4'd10, K_CMD, 8'h71, ERR_EXP},
    {4'd10, K_CMD, 8'h00, ERR_EXP},
    {4'd10, K_CMD, 8'hD0, 16'h0008},  // R10 and R9: nothing changed
    {4'd11, K_IN,  8'h00, 16'h0003},  // R11 IN token on OUT slot
    {4'd1,  K_CMD, 8'h41, NO_CHK},
    {4'd1,  K_CMD, 8'hD1, 16'h0010},
    {4'd1,  K_IN,  8'h01, 16'h0003}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic cv, input logic [7:0] cc, input logic su,
                       input logic tv, input logic ti, input logic [3:0] te,
                       input logic xv, input logic [3:0] xe);
    cmd_valid = cv; cmd_code = cc; setup_stb = su;
    tok_valid = tv; tok_in = ti; tok_ep = te;
    xfer_done = xv; xfer_ep = xe;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; setup_stb = 1'b0; tok_valid = 1'b0; xfer_done = 1'b0;
  endtask

  task automatic do_cmd(input logic [7:0] c);
    pulse(1'b1, c, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0);
  endtask

  task automatic rd_stat(input string req, input logic [3:0] s, input logic [15:0] exp);
    do_cmd({4'hD, s});
    chk(req, stat_valid ? stat_word : 16'hDEAD, exp);
  endtask

  task automatic tok(input string req, input logic in_dir, input logic [3:0] s,
                     input logic [1:0] exp);
    pulse(1'b0, 8'h00, 1'b0, 1'b1, in_dir, s, 1'b0, 4'd0);
    chk(req, resp_valid ? {14'd0, resp_code} : 16'hDEAD, {14'd0, exp});
  endtask

  logic [3:0]  v_req;
  logic [1:0]  v_kind;
  logic [7:0]  v_arg;
  logic [15:0] v_exp;
  string       v_tag;

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_code = 8'h00; setup_stb = 1'b0;
    tok_valid = 1'b0; tok_in = 1'b0; tok_ep = 4'd0;
    xfer_done = 1'b0; xfer_ep = 4'd0;
    repeat (3) @(negedge clk);
    // reset state at the ports (R9, R10)
    chk("R10 reset err", {15'd0, cmd_err}, 16'd0);
    chk("R9 reset stat_valid", {15'd0, stat_valid}, 16'd0);
    chk("R1 reset resp_valid", {15'd0, resp_valid}, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      {v_req, v_kind, v_arg, v_exp} = VEC[k];
      v_tag = $sformatf("R%0d vec%0d", v_req, k);
      case (v_kind)
        K_CMD: begin
          do_cmd(v_arg);
          if (v_exp == ERR_EXP)
            chk(v_tag, {15'd0, cmd_err}, 16'd1);
          else if (v_exp != NO_CHK)
            chk(v_tag, stat_valid ? stat_word : 16'hDEAD, v_exp);
        end
        K_IN, K_OUT: begin
          pulse(1'b0, 8'h00, 1'b0, 1'b1, v_kind == K_IN, v_arg[3:0], 1'b0, 4'd0);
          chk(v_tag, resp_valid ? {14'd0, resp_code} : 16'hDEAD, v_exp);
        end
        default: pulse(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, v_arg[3:0]);
      endcase
    end

    // R3: SETUP unstalls and clears both control slots
    pulse(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0);
    rd_stat("R3 setup slot0", 4'd0, 16'h0000);
    rd_stat("R3 setup slot1", 4'd1, 16'h0000);
    tok("R3 slot1 answers again", 1'b1, 4'd1, 2'b10);
    // R3: SETUP and stall in one cycle, the stall survives
    pulse(1'b1, 8'h40, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0);
    rd_stat("R3 setup+stall", 4'd0, 16'h0010);
    // R7: transfer and clear in one cycle, transfer applied first
    do_cmd(8'h80);
    pulse(1'b1, 8'h70, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 4'd0);
    rd_stat("R7 xfer+clear", 4'd0, 16'h0008);
    // R8: double-buffered OUT slot 2
    pulse(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 4'd2);
    tok("R8 out slot2 second fifo", 1'b0, 4'd2, 2'b01);
    pulse(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 4'd2);
    tok("R6 out slot2 both full", 1'b0, 4'd2, 2'b10);
    rd_stat("R8 slot2 both full", 4'd2, 16'h0006);
    // R7: a further OUT transfer to a full FIFO changes nothing
    pulse(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 4'd2);
    rd_stat("R7 slot2 refused", 4'd2, 16'h0006);
    do_cmd(8'h72);
    rd_stat("R5 slot2 clear fifo0", 4'd2, 16'h0005);
    // R7: transfer on a stalled slot ignored; R2 unstall flushes
    do_cmd(8'h44);
    pulse(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 4'd4);
    rd_stat("R7 stalled xfer", 4'd4, 16'h0010);
    do_cmd(8'h84);
    rd_stat("R2 slot4 unstalled", 4'd4, 16'h0000);
    // R10: error lasts one cycle
    do_cmd(8'h25);
    chk("R10 err high", {15'd0, cmd_err}, 16'd1);
    @(negedge clk);
    chk("R10 err one cycle", {15'd0, cmd_err}, 16'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule